// File: doc/BRIEF.md
# Bus Receiver Failsafe Timeout Controller

This block is the clocked control logic behind the threshold comparators of a differential bus receiver. Each clock it reads two comparator flags, one saying the differential input is above the positive threshold and one saying it is below the negative threshold. It turns them into a three-way bus classification. While the bus carries a valid level, the registered data output follows that level. If the bus stays in the band between the thresholds for a full timeout window, a saturating timer sets a failsafe flag and drives the output high. This happens for an open line, a shorted line or an idle terminated bus. The first valid level clears the timer and the flag on the very next clock edge.

The block also manages power. Whenever the receiver enable (active low) and the driver enable are both inactive, the auxiliary logic drains into a low-power standby state after a short delay. Asserting either enable starts a longer wake-up delay before the logic counts as active again. The output-enable for the external tri-state buffer is only raised when the receiver is enabled and the logic is active. All three delays are set as nanosecond parameters and converted to clock cycles with a clock-frequency parameter given in MHz.

Top module: `rx_failsafe_ctrl`

## Requirements
- R1: With only `cmp_hi` set the bus counts as valid high. With only `cmp_lo` set it counts as valid low. With neither set, or with both set, it counts as undefined.
- R2: While the logic is active, a valid-high or valid-low bus sets `rx_data` to 1 or 0 at the first clock edge that samples it.
- R3: An undefined bus that has not yet timed out leaves `rx_data` at its previous value.
- R4: After TO_CYC consecutive active edges with an undefined bus (TO_CYC = CLK_MHZ*FAILSAFE_NS/1000), `rx_data` is 1. After TO_CYC-1 such edges it still holds the previous value. The timer saturates, so the output stays 1 for as long as the bus stays undefined.
- R5: A valid level clears the timer and the failsafe flag at the next edge, and `rx_data` follows that level in the same edge.
- R6: `rx_oe` is 1 only one edge after the logic is active with `rx_en_n` low. It drops one edge after `rx_en_n` goes high, and it is never 1 during standby.
- R7: With `rx_en_n` high and `drv_en` low, `standby` goes to 1 exactly SLEEP_CYC+1 edges later. If either enable returns before then, the logic goes back to active with no wake-up delay.
- R8: From standby, asserting either enable clears `standby` at the next edge. The logic becomes active after WAKE_CYC+1 edges, so `rx_oe` rises WAKE_CYC+2 edges after `rx_en_n` goes low.
- R9: Reset puts the block in standby with `standby`=1, `rx_oe`=0, `rx_data`=1 and the failsafe flag set. After waking, the output stays 1 until a valid low is seen.
- R10: From the second edge of standby onwards, and during wake-up, `rx_data` is 1 whatever the comparators show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_hi | input | 1 | Comparator flag: differential input above positive threshold |
| cmp_lo | input | 1 | Comparator flag: differential input below negative threshold |
| rx_en_n | input | 1 | Receiver enable, active low |
| drv_en | input | 1 | Driver enable, active high |
| rx_data | output | 1 | Registered receiver data output |
| rx_oe | output | 1 | Output-enable for the tri-state output buffer |
| standby | output | 1 | Auxiliary logic is in low-power standby |

## Verification
The bench builds the block at 125 MHz with FAILSAFE_NS=200, WAKE_NS=80 and SLEEP_NS=40. This gives a timeout of 25 cycles, a wake-up delay of 10 cycles and a standby delay of 5 cycles. The real delays would take tens of thousands of cycles, so these short values make it practical to check each window exactly one edge before and at its end. They also allow a long saturated stretch, re-enabling during the drain, and several full sleep and wake round trips.

// File: rtl/rx_fs_pkg.sv
package rx_fs_pkg;
  typedef enum logic [1:0] {
    BUS_UNDEF = 2'd0,
    BUS_HIGH  = 2'd1,
    BUS_LOW   = 2'd2
  } bus_cls_t;

  typedef enum logic [1:0] {
    PW_SLEEP    = 2'd0,
    PW_WAKING   = 2'd1,
    PW_ACTIVE   = 2'd2,
    PW_DRAINING = 2'd3
  } pwr_state_t;
endpackage

// File: rtl/rx_fs_classify.sv
module rx_fs_classify
  import rx_fs_pkg::*;
(
  input  logic     above_i,
  input  logic     below_i,
  output bus_cls_t cls_o
);
  // Conflicting or absent flags both fall into the undefined band.
  always_comb begin
    unique case ({above_i, below_i})
      2'b10:   cls_o = BUS_HIGH;
      2'b01:   cls_o = BUS_LOW;
      default: cls_o = BUS_UNDEF;
    endcase
  end
endmodule

// File: rtl/rx_fs_timer.sv
module rx_fs_timer
  import rx_fs_pkg::*;
#(
  parameter int TO_CYC = 31250
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     aux_on_i,
  input  bus_cls_t cls_i,
  output logic     fs_o,
  output logic     expire_o
);
  localparam int CW = $clog2(TO_CYC + 1);
  localparam logic [CW-1:0] TO_LAST = CW'(TO_CYC - 1);
  localparam logic [CW-1:0] TO_TOP  = CW'(TO_CYC);

  logic [CW-1:0] cnt_q;
  logic          fs_q;
  logic          undef;

  assign undef    = (cls_i == BUS_UNDEF);
  assign expire_o = aux_on_i && undef && (cnt_q == TO_LAST);
  assign fs_o     = fs_q;

  always_ff @(posedge clk) begin
    if (rst || !aux_on_i) begin
      cnt_q <= '0;
      fs_q  <= 1'b1;
    end else if (!undef) begin
      cnt_q <= '0;
      fs_q  <= 1'b0;
    end else begin
      if (cnt_q != TO_TOP) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == TO_LAST) fs_q <= 1'b1;
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TO_TOP);

  p_sat_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (aux_on_i && undef && cnt_q == TO_TOP) |=> (cnt_q == TO_TOP));

  p_fs_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (aux_on_i && undef && fs_q) |=> fs_q);

  p_valid_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (aux_on_i && !undef) |=> (!fs_q && cnt_q == '0));
endmodule

// File: rtl/rx_fs_power.sv
module rx_fs_power
  import rx_fs_pkg::*;
#(
  parameter int WAKE_CYC  = 1000,
  parameter int SLEEP_CYC = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       want_i,
  output pwr_state_t state_o
);
  localparam int MAXC = (WAKE_CYC > SLEEP_CYC) ? WAKE_CYC : SLEEP_CYC;
  localparam int PW   = $clog2(MAXC + 1);
  localparam logic [PW-1:0] WAKE_LAST  = PW'(WAKE_CYC - 1);
  localparam logic [PW-1:0] SLEEP_LAST = PW'(SLEEP_CYC - 1);

  pwr_state_t    st_q;
  logic [PW-1:0] dly_q;

  assign state_o = st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PW_SLEEP;
      dly_q <= '0;
    end else begin
      unique case (st_q)
        PW_SLEEP: begin
          dly_q <= '0;
          if (want_i) st_q <= PW_WAKING;
        end
        PW_WAKING: begin
          if (!want_i) begin
            st_q  <= PW_SLEEP;
            dly_q <= '0;
          end else if (dly_q == WAKE_LAST) begin
            st_q  <= PW_ACTIVE;
            dly_q <= '0;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        PW_ACTIVE: begin
          dly_q <= '0;
          if (!want_i) st_q <= PW_DRAINING;
        end
        default: begin
          if (want_i) begin
            st_q  <= PW_ACTIVE;
            dly_q <= '0;
          end else if (dly_q == SLEEP_LAST) begin
            st_q  <= PW_SLEEP;
            dly_q <= '0;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
      endcase
    end
  end

  p_no_skip_wake_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == PW_SLEEP) |=> (st_q == PW_SLEEP || st_q == PW_WAKING));

  p_sleep_needs_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q != PW_SLEEP) ##1 (st_q == PW_SLEEP) |-> !$past(want_i));
endmodule

// File: rtl/rx_failsafe_ctrl.sv
module rx_failsafe_ctrl
  import rx_fs_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int FAILSAFE_NS = 250000,
  parameter int WAKE_NS     = 8000,
  parameter int SLEEP_NS    = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_hi,
  input  logic cmp_lo,
  input  logic rx_en_n,
  input  logic drv_en,
  output logic rx_data,
  output logic rx_oe,
  output logic standby
);
  localparam int TO_CYC    = (CLK_MHZ * FAILSAFE_NS) / 1000;
  localparam int WAKE_CYC  = (CLK_MHZ * WAKE_NS) / 1000;
  localparam int SLEEP_CYC = (CLK_MHZ * SLEEP_NS) / 1000;

  bus_cls_t   cls;
  pwr_state_t pst;
  logic       aux_on;
  logic       fs;
  logic       expire;
  logic       want;
  logic       out_q;
  logic       oe_q;

  assign want   = drv_en || !rx_en_n;
  assign aux_on = (pst == PW_ACTIVE) || (pst == PW_DRAINING);

  rx_fs_classify u_cls (
    .above_i (cmp_hi),
    .below_i (cmp_lo),
    .cls_o   (cls)
  );

  rx_fs_timer #(.TO_CYC(TO_CYC)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .aux_on_i (aux_on),
    .cls_i    (cls),
    .fs_o     (fs),
    .expire_o (expire)
  );

  rx_fs_power #(.WAKE_CYC(WAKE_CYC), .SLEEP_CYC(SLEEP_CYC)) u_pwr (
    .clk     (clk),
    .rst     (rst),
    .want_i  (want),
    .state_o (pst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= !rx_en_n && (pst == PW_ACTIVE);
      if (!aux_on)               out_q <= 1'b1;
      else if (cls == BUS_HIGH)  out_q <= 1'b1;
      else if (cls == BUS_LOW)   out_q <= 1'b0;
      else if (fs || expire)     out_q <= 1'b1;
    end
  end

  assign rx_data = out_q;
  assign rx_oe   = oe_q;
  assign standby = (pst == PW_SLEEP);

  p_follow_hi_r2: assert property (@(posedge clk) disable iff (rst)
    (aux_on && cmp_hi && !cmp_lo) |=> rx_data);

  p_follow_lo_r2: assert property (@(posedge clk) disable iff (rst)
    (aux_on && cmp_lo && !cmp_hi) |=> !rx_data);

  p_oe_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
    rx_oe |-> $past(!rx_en_n));

  p_standby_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    standby |-> !rx_oe);

  p_sleep_high_r10: assert property (@(posedge clk) disable iff (rst)
    (standby && $past(standby)) |-> rx_data);
endmodule

// File: tb/rx_failsafe_ctrl_tb_top.sv
module rx_failsafe_ctrl_tb_top;
  localparam int T  = 25;
  localparam int W  = 10;
  localparam int S  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_hi = 1'b0, cmp_lo = 1'b0, rx_en_n = 1'b1, drv_en = 1'b0;
  logic rx_data, rx_oe, standby;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_failsafe_ctrl #(.CLK_MHZ(125), .FAILSAFE_NS(200), .WAKE_NS(80), .SLEEP_NS(40)) dut_i (
    .clk(clk), .rst(rst), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .rx_en_n(rx_en_n), .drv_en(drv_en),
    .rx_data(rx_data), .rx_oe(rx_oe), .standby(standby)
  );

  // {cmp_hi, cmp_lo, expected rx_data}; timer never expires inside the table
  localparam logic [2:0] VEC [10] = '{
    3'b101, 3'b010, 3'b000, 3'b110, 3'b101,
    3'b001, 3'b111, 3'b010, 3'b101, 3'b010
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic bus(input logic h, input logic l);
    cmp_hi = h;
    cmp_lo = l;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    // R9 reset state
    check(standby, 1'b1, "R9", "standby after reset");
    check(rx_oe, 1'b0, "R9", "oe after reset");
    check(rx_data, 1'b1, "R9", "data after reset");

    // R8 wake-up timing
    rx_en_n = 1'b0;
    tick(1);
    check(standby, 1'b0, "R8", "standby clears on enable");
    tick(W);
    check(rx_oe, 1'b0, "R8", "oe still low one edge early");
    tick(1);
    check(rx_oe, 1'b1, "R8", "oe raised after wake delay");
    tick(3);
    check(rx_data, 1'b1, "R9", "failsafe default high on wake");

    // R1 R2 R3 R5 table walk
    for (int i = 0; i < 10; i++) begin
      bus(VEC[i][2], VEC[i][1]);
      tick(1);
      check(rx_data, VEC[i][0], "R1_R2_R3", $sformatf("vector %0d", i));
    end

    // R4 timeout boundary with neither flag
    bus(1'b0, 1'b1);
    tick(1);
    check(rx_data, 1'b0, "R2", "valid low before timeout");
    bus(1'b0, 1'b0);
    tick(T - 1);
    check(rx_data, 1'b0, "R4", "held one edge before timeout");
    tick(1);
    check(rx_data, 1'b1, "R4", "forced high at timeout");
    tick(T + 5);
    check(rx_data, 1'b1, "R4", "saturated timer keeps high");
    bus(1'b0, 1'b1);
    tick(1);
    check(rx_data, 1'b0, "R5", "valid low recovers next edge");

    // R1 both flags count as undefined and time out
    bus(1'b1, 1'b1);
    tick(T - 1);
    check(rx_data, 1'b0, "R1", "conflict held before timeout");
    tick(1);
    check(rx_data, 1'b1, "R1", "conflict times out high");
    bus(1'b0, 1'b1);
    tick(1);
    check(rx_data, 1'b0, "R5", "recovery after conflict timeout");

    // R6 R7 standby entry
    rx_en_n = 1'b1;
    tick(1);
    check(rx_oe, 1'b0, "R6", "oe drops after disable");
    tick(S - 1);
    check(standby, 1'b0, "R7", "not yet standby");
    tick(1);
    check(standby, 1'b1, "R7", "standby after drain");
    tick(1);
    check(rx_data, 1'b1, "R10", "standby forces high over valid low");

    // R6 R8 driver enable wakes without output enable
    drv_en = 1'b1;
    tick(1);
    check(standby, 1'b0, "R8", "driver enable wakes");
    check(rx_data, 1'b1, "R10", "high during wake-up");
    tick(W + 3);
    check(rx_oe, 1'b0, "R6", "oe low with receiver disabled");
    check(rx_data, 1'b0, "R2", "follows low once active");

    // R7 re-enable during drain
    drv_en = 1'b0;
    tick(2);
    drv_en = 1'b1;
    tick(S + 3);
    check(standby, 1'b0, "R7", "re-enable aborts standby");
    rx_en_n = 1'b0;
    tick(1);
    check(rx_oe, 1'b1, "R7", "no wake delay after aborted drain");

    // R9 reset mid-run
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    check(standby, 1'b1, "R9", "standby after second reset");
    check(rx_oe, 1'b0, "R9", "oe after second reset");
    check(rx_data, 1'b1, "R9", "data after second reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule